// File: doc/BRIEF.md
# Host UART Address Decoder

This block sits on the host side of a card that carries a UART and decides, cycle by cycle, whether the current host bus access is meant for the UART register set. It takes the ten host address bits, two active-low card enables and an active-low register-space strobe. From the card's control state it takes an I/O-enable bit, an address-mode bit and a two-bit port select. It produces a UART chip select and the three-bit register index.

The block works in two modes. With address mode on, an access with either card enable low is claimed only when address bits 9 down to 3 equal the upper bits of one of four conventional serial port bases, picked by the port select. With address mode off, the address and the port select play no part: either card enable low together with a low register strobe claims the access. I/O-enable low keeps the UART deselected in both modes. The subsystem owns the port select, the mode bit and the I/O-enable. At reset the surrounding logic sets address mode off and port select 10. Both outputs come from a register one clock after the inputs are sampled.

Top module: `host_uart_decode`

## Requirements
- R1: While rst_ni is low, uart_sel_o is 0 and reg_idx_o is 0, whatever the other inputs are.
- R2: Both outputs are registered: they reflect the inputs sampled at the previous rising clock edge and do not follow an input change before the next edge.
- R3: With addr_mode_i=1 and io_en_i=1, uart_sel_o is 1 exactly when at least one of card_en_a_ni and card_en_b_ni is 0 and host_addr_i[9:3] equals bits 9:3 of the selected base.
- R4: The base chosen by port_sel_i is 00 -> 0x3F8, 01 -> 0x3E8, 10 -> 0x2F8, 11 -> 0x2E8. In other words, base bit 8 is the inverse of port_sel_i[1] and base bit 4 is the inverse of port_sel_i[0], and base bits 9, 7, 6, 5 and 3 are 1.
- R5: In address mode an access is refused (uart_sel_o=0) when any one of host_addr_i bits 9:3 differs from the selected base, even with a card enable active.
- R6: With addr_mode_i=0 and io_en_i=1, uart_sel_o is 1 when either card enable is 0 and reg_space_ni is 0. host_addr_i and port_sel_i have no effect on uart_sel_o.
- R7: With addr_mode_i=0, uart_sel_o is 0 when both card enables are 1 or reg_space_ni is 1.
- R8: With io_en_i=0, uart_sel_o is 0 in both modes.
- R9: reg_idx_o is host_addr_i[2:0], registered, in every cycle whether or not the UART is selected. Bits 2:0 never affect uart_sel_o.
- R10: In address mode, reg_space_ni has no effect on uart_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 10 | Host address bits 9:0 |
| card_en_a_ni | input | 1 | First card enable, active low |
| card_en_b_ni | input | 1 | Second card enable, active low |
| reg_space_ni | input | 1 | Register-space strobe, active low |
| io_en_i | input | 1 | I/O operation enabled |
| addr_mode_i | input | 1 | 1 selects address comparison, 0 selects strobe-only decode |
| port_sel_i | input | 2 | Serial port base select |
| uart_sel_o | output | 1 | UART chip select, registered |
| reg_idx_o | output | 3 | UART register index, registered |

## Verification
The bench walks each of the four port selects through its exact base and through a one-bit flip of every address bit. A design with the select bits swapped or inverted, or with a fixed bit dropped from the compare, then claims a wrong base or misses the right one. Bits 2:0 are flipped as well, because a design that compares the full address refuses legal register offsets. In strobe-only mode the address and select are scrambled and every enable and strobe combination is applied, so a decoder that still looks at the address, or that needs both enables, drops valid cycles. Further cases clear I/O-enable in both modes and raise the register strobe in address mode, and the output is checked before the clock edge to catch a decoder that has lost its register.

// File: rtl/hud_pkg.sv
package hud_pkg;
  localparam int unsigned ADDR_W   = 10;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned PORT_CNT = 4;
  localparam int unsigned SEL_W    = $clog2(PORT_CNT);

  typedef enum logic {
    DEC_STROBE = 1'b0,
    DEC_ADDR   = 1'b1
  } dec_mode_e;
endpackage

// File: rtl/hud_base_table.sv
module hud_base_table #(
  parameter int unsigned          ADDR_W     = hud_pkg::ADDR_W,
  parameter int unsigned          PORT_CNT   = hud_pkg::PORT_CNT,
  parameter int unsigned          SEL_W      = hud_pkg::SEL_W,
  parameter logic [ADDR_W-1:0]    BASE_FLOOR = 10'h2E8,
  parameter int unsigned          HI_BIT     = 8,
  parameter int unsigned          LO_BIT     = 4
) (
  output logic [PORT_CNT-1:0][ADDR_W-1:0] base_o
);
  localparam logic [ADDR_W-1:0] ONE_V  = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] HI_ONE = ONE_V << HI_BIT;
  localparam logic [ADDR_W-1:0] LO_ONE = ONE_V << LO_BIT;

  // a clear select bit lifts the matching base bit
  for (genvar i = 0; i < PORT_CNT; i++) begin : g_base
    localparam logic [SEL_W-1:0] SEL_V = SEL_W'(i);
    assign base_o[i] = BASE_FLOOR
                     | (SEL_V[SEL_W-1] ? '0 : HI_ONE)
                     | (SEL_V[0]       ? '0 : LO_ONE);
  end
endmodule

// File: rtl/hud_addr_match.sv
module hud_addr_match #(
  parameter int unsigned ADDR_W   = hud_pkg::ADDR_W,
  parameter int unsigned IDX_W    = hud_pkg::IDX_W,
  parameter int unsigned PORT_CNT = hud_pkg::PORT_CNT,
  parameter int unsigned SEL_W    = hud_pkg::SEL_W
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  logic [PORT_CNT-1:0][ADDR_W-1:0] base_i,
  output logic                            hit_o
);
  localparam int unsigned CMP_W = ADDR_W - IDX_W;

  logic [CMP_W-1:0] want;
  logic [CMP_W-1:0] have;

  assign want  = base_i[sel_i][ADDR_W-1:IDX_W];
  assign have  = addr_i[ADDR_W-1:IDX_W];
  assign hit_o = (want == have);
endmodule

// File: rtl/hud_cycle_qual.sv
module hud_cycle_qual (
  input  logic              card_en_a_ni,
  input  logic              card_en_b_ni,
  input  logic              reg_space_ni,
  input  logic              io_en_i,
  input  hud_pkg::dec_mode_e mode_i,
  input  logic              addr_hit_i,
  output logic              sel_o
);
  logic card_act;

  assign card_act = ~card_en_a_ni | ~card_en_b_ni;

  always_comb begin
    sel_o = 1'b0;
    if (io_en_i && card_act) begin
      unique case (mode_i)
        hud_pkg::DEC_ADDR:   sel_o = addr_hit_i;
        hud_pkg::DEC_STROBE: sel_o = ~reg_space_ni;
        default:             sel_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/host_uart_decode.sv
module host_uart_decode #(
  parameter int unsigned ADDR_W   = hud_pkg::ADDR_W,
  parameter int unsigned IDX_W    = hud_pkg::IDX_W,
  parameter int unsigned PORT_CNT = hud_pkg::PORT_CNT,
  parameter int unsigned SEL_W    = hud_pkg::SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              card_en_a_ni,
  input  logic              card_en_b_ni,
  input  logic              reg_space_ni,
  input  logic              io_en_i,
  input  logic              addr_mode_i,
  input  logic [SEL_W-1:0]  port_sel_i,
  output logic              uart_sel_o,
  output logic [IDX_W-1:0]  reg_idx_o
);
  logic [PORT_CNT-1:0][ADDR_W-1:0] base_tab;
  logic                            addr_hit;
  logic                            sel_d;
  hud_pkg::dec_mode_e              mode;

  assign mode = addr_mode_i ? hud_pkg::DEC_ADDR : hud_pkg::DEC_STROBE;

  hud_base_table #(
    .ADDR_W  (ADDR_W),
    .PORT_CNT(PORT_CNT),
    .SEL_W   (SEL_W)
  ) u_tab (
    .base_o(base_tab)
  );

  hud_addr_match #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .PORT_CNT(PORT_CNT),
    .SEL_W   (SEL_W)
  ) u_match (
    .addr_i(host_addr_i),
    .sel_i (port_sel_i),
    .base_i(base_tab),
    .hit_o (addr_hit)
  );

  hud_cycle_qual u_qual (
    .card_en_a_ni(card_en_a_ni),
    .card_en_b_ni(card_en_b_ni),
    .reg_space_ni(reg_space_ni),
    .io_en_i     (io_en_i),
    .mode_i      (mode),
    .addr_hit_i  (addr_hit),
    .sel_o       (sel_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uart_sel_o <= 1'b0;
      reg_idx_o  <= '0;
    end else begin
      uart_sel_o <= sel_d;
      reg_idx_o  <= host_addr_i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/hud_checker.sv
module hud_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [9:0] host_addr_i,
  input logic       card_en_a_ni,
  input logic       card_en_b_ni,
  input logic       reg_space_ni,
  input logic       io_en_i,
  input logic       addr_mode_i,
  input logic [1:0] port_sel_i,
  input logic       uart_sel_o,
  input logic [2:0] reg_idx_o
);
  logic [9:0] exp_base;
  always_comb begin
    case (port_sel_i)
      2'b00:   exp_base = 10'h3F8;
      2'b01:   exp_base = 10'h3E8;
      2'b10:   exp_base = 10'h2F8;
      default: exp_base = 10'h2E8;
    endcase
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (uart_sel_o == 1'b0 && reg_idx_o == 3'd0));

  a_r8_io_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_en_i |=> !uart_sel_o);

  a_r7_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_mode_i && (reg_space_ni || (card_en_a_ni && card_en_b_ni))) |=> !uart_sel_o);

  a_r5_refuse_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_mode_i && host_addr_i[9:3] != exp_base[9:3]) |=> !uart_sel_o);

  a_r3_claim_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_mode_i && io_en_i && !(card_en_a_ni && card_en_b_ni)
     && host_addr_i[9:3] == exp_base[9:3]) |=> uart_sel_o);

  a_r9_idx_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> reg_idx_o == $past(host_addr_i[2:0]));
endmodule

bind host_uart_decode hud_checker u_hud_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_addr_i (host_addr_i),
  .card_en_a_ni(card_en_a_ni),
  .card_en_b_ni(card_en_b_ni),
  .reg_space_ni(reg_space_ni),
  .io_en_i     (io_en_i),
  .addr_mode_i (addr_mode_i),
  .port_sel_i  (port_sel_i),
  .uart_sel_o  (uart_sel_o),
  .reg_idx_o   (reg_idx_o)
);

// File: tb/host_uart_decode_tb_top.sv
module host_uart_decode_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] host_addr_i = '0;
  logic       card_en_a_ni = 1'b1;
  logic       card_en_b_ni = 1'b1;
  logic       reg_space_ni = 1'b1;
  logic       io_en_i = 1'b0;
  logic       addr_mode_i = 1'b0;
  logic [1:0] port_sel_i = 2'b10;
  logic       uart_sel_o;
  logic [2:0] reg_idx_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic       sel;
    logic [2:0] idx;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  host_uart_decode dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_addr_i (host_addr_i),
    .card_en_a_ni(card_en_a_ni),
    .card_en_b_ni(card_en_b_ni),
    .reg_space_ni(reg_space_ni),
    .io_en_i     (io_en_i),
    .addr_mode_i (addr_mode_i),
    .port_sel_i  (port_sel_i),
    .uart_sel_o  (uart_sel_o),
    .reg_idx_o   (reg_idx_o)
  );

  function automatic logic [9:0] base_of(input logic [1:0] s);
    case (s)
      2'b00:   return 10'h3F8;
      2'b01:   return 10'h3E8;
      2'b10:   return 10'h2F8;
      default: return 10'h2E8;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic [9:0] a, input logic ena_n, input logic enb_n,
                       input logic rs_n, input logic io, input logic md,
                       input logic [1:0] ps, input string tag);
    exp_t e;
    logic act;
    @(negedge clk_i);
    host_addr_i  = a;
    card_en_a_ni = ena_n;
    card_en_b_ni = enb_n;
    reg_space_ni = rs_n;
    io_en_i      = io;
    addr_mode_i  = md;
    port_sel_i   = ps;
    act   = !ena_n || !enb_n;
    e.sel = io && act && (md ? (a[9:3] == base_of(ps)[9:3]) : !rs_n);
    e.idx = a[2:0];
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: one item per clock, sampled just after the edge
  always @(posedge clk_i) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(uart_sel_o === e.sel, {e.tag, " sel"}, int'(uart_sel_o), int'(e.sel));
      check(reg_idx_o === e.idx, "R9 idx", int'(reg_idx_o), int'(e.idx));
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: selecting inputs held while in reset
    host_addr_i  = 10'h2FD;
    card_en_a_ni = 1'b0;
    reg_space_ni = 1'b0;
    io_en_i      = 1'b1;
    repeat (3) @(posedge clk_i);
    #2;
    check(uart_sel_o === 1'b0, "R1 sel in reset", int'(uart_sel_o), 0);
    check(reg_idx_o === 3'd0, "R1 idx in reset", int'(reg_idx_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 R4: exact base per select, both enables
    for (int s = 0; s < 4; s++) begin
      logic [9:0] b;
      b = base_of(2'(s));
      drive(b, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'(s), "R4 base hit");
      drive(b | 10'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'(s), "R3 enable b");
      drive(b, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'(s), "R3 no enable");
      // R5: flip each compared bit; bits 2:0 must still hit (R9)
      for (int k = 0; k < 10; k++)
        drive(b ^ (10'd1 << k), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'(s),
              (k < 3) ? "R9 low bits" : "R5 bit flip");
      // R4: the other bases must miss
      for (int t = 0; t < 4; t++)
        if (t != s) drive(base_of(2'(t)), 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'(s), "R4 other base");
    end

    // R10: register strobe high in address mode
    drive(10'h3F8, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, "R10 strobe high");
    drive(10'h3F8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, "R10 strobe low");

    // R6 R7: strobe-only mode, all enable/strobe combos, random address/select
    for (int n = 0; n < 8; n++) begin
      for (int c = 0; c < 8; c++)
        drive(10'($urandom), c[0], c[1], c[2], 1'b1, 1'b0, 2'($urandom),
              (c[2] == 1'b0 && c[1:0] != 2'b11) ? "R6 strobe sel" : "R7 no sel");
    end

    // R8: io disabled in both modes
    drive(10'h2F8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, "R8 addr mode off");
    drive(10'h123, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, "R8 strobe mode off");

    // R2: output holds until the next edge
    drive(10'h000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, "R2 idle");
    drive(10'h2E9, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, "R2 claim");
    #1;
    check(uart_sel_o === 1'b0, "R2 before edge", int'(uart_sel_o), 0);

    drive(10'h000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b10, "R7 tail");
    repeat (3) @(posedge clk_i);
    #2;
    check(sb_q.size() == 0, "R2 queue drained", sb_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule